// File: doc/BRIEF.md
# Device Page Request Sequencer

This block sits in an endpoint function that uses address translation services. When the device translation cache reports a miss on a page, the block does not retry the translation straight away. It claims a group index from a small pool and sends a page request toward the root. The request carries the page address and that index. The block keeps the page in a slot named by the index. A response can come back later with an index and a status. The block matches the response to the outstanding request by index and frees the slot. If the status reports success, meaning the page is now resident, it issues a translation request for the stored page. If the status reports failure, it raises a fault for that page and makes no translation request.

More than one request can be outstanding, up to the size of the pool. Responses may return in any order. While every index is in use, the block holds off new misses. A response whose index matches no outstanding request is dropped and reported on an error strobe.

Top module: `page_req_seq`

## Requirements
- R1: After reset, `reqValid`, `xlatValid`, `faultValid` and `rspErr` are low and `missReady` is high.
- R2: A miss is accepted at a clock edge where `missValid` and `missReady` are both high. In the cycle after that edge, `reqValid` is high for one cycle, `reqPage` equals the missed page, and `reqIdx` holds the index that was claimed.
- R3: An accepted miss always claims the lowest-numbered index that is free.
- R4: `missReady` is low exactly when all POOL indices are outstanding. A miss presented while it is low is ignored, and no request follows it.
- R5: A response with `rspOk`=1 whose index is outstanding makes `xlatValid` high for one cycle in the next cycle, with `xlatPage` equal to the page stored for that index. The index then becomes free.
- R6: A response with `rspOk`=0 whose index is outstanding makes `faultValid` high for one cycle in the next cycle, with `faultPage` equal to the stored page. No translation request is made, and the index becomes free.
- R7: A response whose index is not outstanding makes `rspErr` high for one cycle in the next cycle. It produces no translation request and no fault, and it changes no index allocation.
- R8: Responses may arrive in any order. Each one is paired with its own request by index.
- R9: A miss and a response in the same cycle are both handled. The miss claims from the indices that were free before the response releases its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | Translation cache reports a miss |
| missPage | input | PAGE_W | Page address of the miss |
| missReady | output | 1 | A group index is free, so a miss can be accepted |
| reqValid | output | 1 | Page request toward the link |
| reqPage | output | PAGE_W | Page address of the request |
| reqIdx | output | IDX_W | Group index of the request |
| rspValid | input | 1 | Group response from the link |
| rspIdx | input | IDX_W | Group index of the response |
| rspOk | input | 1 | 1 = page made resident, 0 = failure |
| xlatValid | output | 1 | Translation request issued |
| xlatPage | output | PAGE_W | Page of the translation request |
| faultValid | output | 1 | Sequence ended in failure |
| faultPage | output | PAGE_W | Page whose request failed |
| rspErr | output | 1 | Response index matched no outstanding request |

## Verification
The hardest situation to reach from the ports is a miss and a response landing in the same cycle while the pool has exactly one hole. This case shows whether a new claim can see the index that is being freed in that same cycle. To get there, the stimulus first fills the pool. It then frees one index out of order and refills it, and fails another index and probes it again with a stale response. Finally it drives a miss together with a success response on index 0. The expected result is that the request takes index 1 and not index 0, and that the next miss then takes index 0.

// File: rtl/page_req_seq_pkg.sv
package page_req_seq_pkg;
  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic alloc;    // claim a free index for the presented miss
    logic release_; // free the index named by the response
    logic grant;    // response succeeded: issue translation request
    logic fail;     // response failed: raise fault
    logic stray;    // response matched nothing
  } strobes_t;
endpackage

// File: rtl/page_req_seq_ctrl.sv
module page_req_seq_ctrl
  import page_req_seq_pkg::*;
#(
  parameter int POOL  = 4,
  parameter int IDX_W = (POOL > 1) ? $clog2(POOL) : 1
) (
  input  logic             missValid,
  input  logic             rspValid,
  input  logic [IDX_W-1:0] rspIdx,
  input  logic             rspOk,
  input  logic [POOL-1:0]  slotBusy,
  output logic             missReady,
  output logic [IDX_W-1:0] allocIdx,
  output strobes_t         strobes
);
  logic anyFree;
  logic hit;

  // lowest-numbered free slot wins
  always_comb begin
    anyFree  = 1'b0;
    allocIdx = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (!slotBusy[i]) begin
        anyFree  = 1'b1;
        allocIdx = IDX_W'(i);
      end
    end
  end

  // index compare per slot guards against indices beyond the pool
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < POOL; i++) begin
      if (rspIdx == IDX_W'(i) && slotBusy[i]) hit = 1'b1;
    end
  end

  assign missReady = anyFree;

  always_comb begin
    strobes          = '0;
    strobes.alloc    = missValid && anyFree;
    strobes.release_ = rspValid && hit;
    strobes.grant    = rspValid && hit && rspOk;
    strobes.fail     = rspValid && hit && !rspOk;
    strobes.stray    = rspValid && !hit;
  end
endmodule

// File: rtl/page_req_seq_data.sv
module page_req_seq_data
  import page_req_seq_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int POOL   = 4,
  parameter int IDX_W  = (POOL > 1) ? $clog2(POOL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [IDX_W-1:0]  rspIdx,
  input  logic [PAGE_W-1:0] missPage,
  output logic [POOL-1:0]   slotBusy,
  output logic              reqValid,
  output logic [PAGE_W-1:0] reqPage,
  output logic [IDX_W-1:0]  reqIdx,
  output logic              xlatValid,
  output logic [PAGE_W-1:0] xlatPage,
  output logic              faultValid,
  output logic [PAGE_W-1:0] faultPage,
  output logic              rspErr
);
  logic [PAGE_W-1:0] slotPage [POOL];
  logic [PAGE_W-1:0] relPage;

  for (genvar g = 0; g < POOL; g++) begin : gSlot
    logic setHere, clrHere;
    assign setHere = strobes.alloc    && (allocIdx == IDX_W'(g));
    assign clrHere = strobes.release_ && (rspIdx   == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotBusy[g] <= 1'b0;
        slotPage[g] <= '0;
      end else if (setHere) begin
        slotBusy[g] <= 1'b1;
        slotPage[g] <= missPage;
      end else if (clrHere) begin
        slotBusy[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    relPage = '0;
    for (int i = 0; i < POOL; i++) begin
      if (rspIdx == IDX_W'(i)) relPage = slotPage[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid   <= 1'b0;
      reqPage    <= '0;
      reqIdx     <= '0;
      xlatValid  <= 1'b0;
      xlatPage   <= '0;
      faultValid <= 1'b0;
      faultPage  <= '0;
      rspErr     <= 1'b0;
    end else begin
      reqValid   <= strobes.alloc;
      xlatValid  <= strobes.grant;
      faultValid <= strobes.fail;
      rspErr     <= strobes.stray;
      if (strobes.alloc) begin
        reqPage <= missPage;
        reqIdx  <= allocIdx;
      end
      if (strobes.grant) xlatPage  <= relPage;
      if (strobes.fail)  faultPage <= relPage;
    end
  end
endmodule

// File: rtl/page_req_seq.sv
module page_req_seq
  import page_req_seq_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int POOL   = 4,
  parameter int IDX_W  = (POOL > 1) ? $clog2(POOL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [PAGE_W-1:0] missPage,
  output logic              missReady,
  output logic              reqValid,
  output logic [PAGE_W-1:0] reqPage,
  output logic [IDX_W-1:0]  reqIdx,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspIdx,
  input  logic              rspOk,
  output logic              xlatValid,
  output logic [PAGE_W-1:0] xlatPage,
  output logic              faultValid,
  output logic [PAGE_W-1:0] faultPage,
  output logic              rspErr
);
  strobes_t         strobes;
  logic [POOL-1:0]  slotBusy;
  logic [IDX_W-1:0] allocIdx;

  page_req_seq_ctrl #(.POOL(POOL), .IDX_W(IDX_W)) u_ctrl (
    .missValid(missValid), .rspValid(rspValid), .rspIdx(rspIdx),
    .rspOk(rspOk), .slotBusy(slotBusy), .missReady(missReady),
    .allocIdx(allocIdx), .strobes(strobes)
  );

  page_req_seq_data #(.PAGE_W(PAGE_W), .POOL(POOL), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .allocIdx(allocIdx),
    .rspIdx(rspIdx), .missPage(missPage), .slotBusy(slotBusy),
    .reqValid(reqValid), .reqPage(reqPage), .reqIdx(reqIdx),
    .xlatValid(xlatValid), .xlatPage(xlatPage),
    .faultValid(faultValid), .faultPage(faultPage), .rspErr(rspErr)
  );
endmodule

// File: rtl/page_req_seq_chk.sv
module page_req_seq_chk #(
  parameter int PAGE_W = 20,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic [PAGE_W-1:0] missPage,
  input logic              missReady,
  input logic              reqValid,
  input logic [PAGE_W-1:0] reqPage,
  input logic              rspValid,
  input logic              rspOk,
  input logic              xlatValid,
  input logic              faultValid,
  input logic              rspErr
);
  // R2: a request follows an accepted miss, carrying its page
  assert_req_follows_miss_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($past(missValid && missReady) && reqPage == $past(missPage)));

  // R4: a miss offered while stalled produces no request
  assert_stall_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !missReady) |=> !reqValid);

  // R5: translation request only after a successful response
  assert_xlat_after_ok_R5: assert property (@(posedge clk) disable iff (!rstN)
    xlatValid |-> $past(rspValid && rspOk));

  // R6: fault only after a failing response, never together with a translation request
  assert_fault_after_fail_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> ($past(rspValid && !rspOk) && !xlatValid));

  // R7: stray report only after a response, and without any other outcome
  assert_stray_alone_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> ($past(rspValid) && !xlatValid && !faultValid));
endmodule

bind page_req_seq page_req_seq_chk #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .missValid(missValid), .missPage(missPage),
  .missReady(missReady), .reqValid(reqValid), .reqPage(reqPage),
  .rspValid(rspValid), .rspOk(rspOk), .xlatValid(xlatValid),
  .faultValid(faultValid), .rspErr(rspErr)
);

// File: tb/page_req_seq_bench.sv
`timescale 1ns/1ps
module page_req_seq_bench;
  localparam int PAGE_W = 20;
  localparam int POOL   = 4;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [PAGE_W-1:0] missPage = '0;
  logic missReady;
  logic reqValid;
  logic [PAGE_W-1:0] reqPage;
  logic [IDX_W-1:0] reqIdx;
  logic rspValid = 1'b0;
  logic [IDX_W-1:0] rspIdx = '0;
  logic rspOk = 1'b0;
  logic xlatValid;
  logic [PAGE_W-1:0] xlatPage;
  logic faultValid;
  logic [PAGE_W-1:0] faultPage;
  logic rspErr;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  page_req_seq #(.PAGE_W(PAGE_W), .POOL(POOL)) u_page_req_seq (.*);

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // present a miss; sample one cycle after the accepting edge
  task automatic doMiss(input logic [PAGE_W-1:0] pg, input bit expAccept,
                        input int expIdx, input string req);
    @(negedge clk);
    missValid = 1'b1; missPage = pg;
    @(posedge clk); #1;
    check(req, "reqValid", reqValid, expAccept);
    if (expAccept) begin
      check(req, "reqPage", reqPage, pg);
      check(req, "reqIdx", reqIdx, expIdx);
    end
    @(negedge clk);
    missValid = 1'b0;
  endtask

  // present a response; kind: 0=grant 1=fault 2=stray
  task automatic doRsp(input int idx, input bit ok, input int kind,
                       input logic [PAGE_W-1:0] expPage, input string req);
    @(negedge clk);
    rspValid = 1'b1; rspIdx = IDX_W'(idx); rspOk = ok;
    @(posedge clk); #1;
    check(req, "xlatValid", xlatValid, kind == 0);
    check(req, "faultValid", faultValid, kind == 1);
    check(req, "rspErr", rspErr, kind == 2);
    if (kind == 0) check(req, "xlatPage", xlatPage, expPage);
    if (kind == 1) check(req, "faultPage", faultPage, expPage);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic testReset();
    // R1
    check("R1", "reqValid", reqValid, 0);
    check("R1", "xlatValid", xlatValid, 0);
    check("R1", "faultValid", faultValid, 0);
    check("R1", "rspErr", rspErr, 0);
    check("R1", "missReady", missReady, 1);
  endtask

  task automatic testFill();
    // R2 R3: indices claimed lowest first
    for (int i = 0; i < POOL; i++) doMiss(20'hA0000 + i, 1'b1, i, "R3");
    check("R4", "missReady when full", missReady, 0);
  endtask

  task automatic testStall();
    doMiss(20'hDEAD0, 1'b0, 0, "R4");
    check("R4", "missReady still low", missReady, 0);
  endtask

  task automatic testOutOfOrder();
    // R8 R5: index 2 answered first
    doRsp(2, 1'b1, 0, 20'hA0002, "R8");
    check("R5", "missReady after release", missReady, 1);
    doMiss(20'hB0002, 1'b1, 2, "R3");
  endtask

  task automatic testFailure();
    doRsp(1, 1'b0, 1, 20'hA0001, "R6");
    // R7: stale index 1 now matches nothing
    doRsp(1, 1'b1, 2, '0, "R7");
  endtask

  task automatic testSameCycle();
    // R9: index 1 free; index 0 released in same cycle as the miss
    @(negedge clk);
    missValid = 1'b1; missPage = 20'hC0001;
    rspValid = 1'b1; rspIdx = 0; rspOk = 1'b1;
    @(posedge clk); #1;
    check("R9", "reqValid", reqValid, 1);
    check("R9", "reqIdx", reqIdx, 1);
    check("R9", "xlatValid", xlatValid, 1);
    check("R9", "xlatPage", xlatPage, 20'hA0000);
    @(negedge clk);
    missValid = 1'b0; rspValid = 1'b0;
    doMiss(20'hC0000, 1'b1, 0, "R9");
    // R5: index 3 still pairs with its original page
    doRsp(3, 1'b1, 0, 20'hA0003, "R5");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testFill();
    testStall();
    testOutOfOrder();
    testFailure();
    testSameCycle();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule